// File: doc/BRIEF.md
# Memory Cycle Strobe Timer

This block produces every timing strobe of one storage-array cycle from a single request. It behaves like a tapped delay line: a shift register advances one stage per clock (10 ns per stage at 100 MHz), and a request injects a pulse at the head. The pulse length is set by feedback from an early tap, which stops the injection once the leading edge gets there. Each of the five strobes is a set/reset flop. One tap sets it, so that tap fixes its delay from the request. A second tap clears it, so that tap fixes its width.

A read request and a write request both start the same cycle. A busy flag stays high while the pulse travels towards the lockout tap. Requests that arrive in that window are dropped, not queued. The lockout tap therefore fixes the shortest spacing between cycles. With the default settings this is 80 clocks, an 800 ns cycle. The sense strobe closes at 300 ns, and the digit enable opens only after the sense strobe has closed.

Top module: `cyc_timer`

## Requirements
- R1: While rst_ni is low, all six outputs are low at once. After release with no request, they stay low.
- R2: A cycle is launched at a clock edge where rd_req_i or wr_req_i is sampled high after both were low at the previous edge, and busy_o is low. Read and write requests give identical timing. Call the launch edge edge 0; cycle n is the clock period after edge n.
- R3: The injected pulse is PULSE_W taps long. It is ended by feedback from tap PULSE_W.
- R4: Each strobe is high exactly in cycles ON..OFF-1 of its tap pair. The default pairs are rd_sel (1,30), rd_src (3,28), sense_stb (22,30), dig_en (34,60) and wr_src (36,62). The rule holds when OFF ≥ ON+PULSE_W and OFF < LOCK_TAP.
- R5: busy_o is high in cycles 0..LOCK_TAP+PULSE_W-3 after a launch. With the defaults that is 79 cycles.
- R6: A rising request sampled while busy_o is high is ignored. It is not remembered, and it launches nothing later.
- R7: A request held high for any length of time launches only one cycle.
- R8: The earliest accepted relaunch is LOCK_TAP+PULSE_W-1 edges after the previous launch. This is 80 edges with the defaults.
- R9: sense_stb_o and dig_en_o are never high in the same cycle.
- R10: A reset applied in the middle of a cycle removes the pulse. No strobe reappears after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Line clock, one tap per period |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_req_i | input | 1 | Read cycle request |
| wr_req_i | input | 1 | Write cycle request |
| rd_sel_o | output | 1 | Address decode / word select timing |
| rd_src_o | output | 1 | Read current source timing |
| sense_stb_o | output | 1 | Sense amplifier strobe |
| dig_en_o | output | 1 | Digit driver enable timing |
| wr_src_o | output | 1 | Write current source timing |
| busy_o | output | 1 | Lockout in progress |

## Verification
The results come out at known times after the launch edge. A strobe first reads high in the period after edge ON and first reads low in the period after edge OFF. busy_o falls after edge LOCK_TAP+PULSE_W-2. The bench counts clock edges and keeps its own record of accepted launches, using the R2 and R8 rules. It samples every output on the falling clock edge, halfway between the register updates, and compares it with the window value for that period. Two configurations run side by side, so the pulse-width term in R5 and R8 is checked with both a one-tap and a three-tap pulse.

// File: rtl/cyc_timer_pkg.sv
`timescale 1ns/1ps
package cyc_timer_pkg;
  localparam int unsigned NUM_STB = 5;

  typedef enum int unsigned {
    STB_RD_SEL = 0,
    STB_RD_SRC = 1,
    STB_SENSE  = 2,
    STB_DIG_EN = 3,
    STB_WR_SRC = 4
  } stb_e;

  typedef logic [NUM_STB-1:0] stb_vec_t;
endpackage

// File: rtl/cyc_req_gate.sv
`timescale 1ns/1ps
module cyc_req_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_req_i,
  input  logic wr_req_i,
  input  logic busy_i,
  output logic launch_o
);
  logic any_req;
  logic req_q;

  assign any_req = rd_req_i | wr_req_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= 1'b0;
    else         req_q <= any_req;
  end

  // rising edge only, dropped while locked out
  assign launch_o = any_req & ~req_q & ~busy_i;
endmodule

// File: rtl/cyc_tap_line.sv
`timescale 1ns/1ps
module cyc_tap_line #(
  parameter int unsigned PULSE_W  = 1,
  parameter int unsigned LOCK_TAP = 80
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  launch_i,
  output logic [LOCK_TAP-1:1]   taps_o,
  output logic                  busy_o
);
  localparam int unsigned LINE_LEN = LOCK_TAP - 1;

  logic [LINE_LEN:1] taps_q;
  logic              head;

  // keep feeding until the leading edge reaches the width tap
  assign head = launch_i | (taps_q[1] & ~taps_q[PULSE_W]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) taps_q <= '0;
    else         taps_q <= {taps_q[LINE_LEN-1:1], head};
  end

  // pulse still inside the lockout span
  assign busy_o = |taps_q;
  assign taps_o = taps_q;

  a_r3_pulse_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(taps_q[1]) |-> taps_q[PULSE_W+1]);

  a_r6_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(taps_q[1]) |-> (taps_q[LINE_LEN:2] == '0));
endmodule

// File: rtl/cyc_window.sv
`timescale 1ns/1ps
module cyc_window (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic win_o
);
  logic win_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    win_q <= 1'b0;
    else if (set_i) win_q <= 1'b1;
    else if (clr_i) win_q <= 1'b0;
  end

  assign win_o = win_q;

  a_r4_no_clash: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(set_i && clr_i));

  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_i && !clr_i) |=> $stable(win_o));
endmodule

// File: rtl/cyc_timer.sv
`timescale 1ns/1ps
module cyc_timer
  import cyc_timer_pkg::*;
#(
  parameter int unsigned PULSE_W  = 1,
  parameter int unsigned LOCK_TAP = 80,
  parameter int unsigned SEL_ON   = 1,
  parameter int unsigned SEL_OFF  = 30,
  parameter int unsigned RSRC_ON  = 3,
  parameter int unsigned RSRC_OFF = 28,
  parameter int unsigned STB_ON   = 22,
  parameter int unsigned STB_OFF  = 30,
  parameter int unsigned DEN_ON   = 34,
  parameter int unsigned DEN_OFF  = 60,
  parameter int unsigned WSRC_ON  = 36,
  parameter int unsigned WSRC_OFF = 62
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_req_i,
  input  logic wr_req_i,
  output logic rd_sel_o,
  output logic rd_src_o,
  output logic sense_stb_o,
  output logic dig_en_o,
  output logic wr_src_o,
  output logic busy_o
);
  localparam int unsigned LINE_LEN = LOCK_TAP - 1;
  localparam int unsigned ON_TAP  [NUM_STB] = '{SEL_ON, RSRC_ON, STB_ON, DEN_ON, WSRC_ON};
  localparam int unsigned OFF_TAP [NUM_STB] = '{SEL_OFF, RSRC_OFF, STB_OFF, DEN_OFF, WSRC_OFF};

  logic              launch;
  logic              busy;
  logic [LINE_LEN:1] taps;
  stb_vec_t          win;

  cyc_req_gate u_gate (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_req_i (rd_req_i),
    .wr_req_i (wr_req_i),
    .busy_i   (busy),
    .launch_o (launch)
  );

  cyc_tap_line #(
    .PULSE_W  (PULSE_W),
    .LOCK_TAP (LOCK_TAP)
  ) u_line (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .launch_i (launch),
    .taps_o   (taps),
    .busy_o   (busy)
  );

  for (genvar k = 0; k < NUM_STB; k++) begin : g_win
    cyc_window u_win (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (taps[ON_TAP[k]]),
      .clr_i  (taps[OFF_TAP[k]]),
      .win_o  (win[k])
    );
  end

  assign rd_sel_o    = win[STB_RD_SEL];
  assign rd_src_o    = win[STB_RD_SRC];
  assign sense_stb_o = win[STB_SENSE];
  assign dig_en_o    = win[STB_DIG_EN];
  assign wr_src_o    = win[STB_WR_SRC];
  assign busy_o      = busy;

  a_r9_sense_vs_digit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sense_stb_o && dig_en_o));

  a_r5_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (win == '0));
endmodule

// File: tb/cyc_timer_test.sv
`timescale 1ns/1ps
module cyc_timer_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_req = 1'b0;
  logic wr_req = 1'b0;

  always #2.5 clk = ~clk;

  logic [5:0] got [2];

  cyc_timer uut (
    .clk_i(clk), .rst_ni(rst_n), .rd_req_i(rd_req), .wr_req_i(wr_req),
    .rd_sel_o(got[0][0]), .rd_src_o(got[0][1]), .sense_stb_o(got[0][2]),
    .dig_en_o(got[0][3]), .wr_src_o(got[0][4]), .busy_o(got[0][5])
  );

  cyc_timer #(
    .PULSE_W(3), .LOCK_TAP(20),
    .SEL_ON(1), .SEL_OFF(5), .RSRC_ON(2), .RSRC_OFF(6),
    .STB_ON(6), .STB_OFF(10), .DEN_ON(11), .DEN_OFF(15),
    .WSRC_ON(12), .WSRC_OFF(18)
  ) uut_b (
    .clk_i(clk), .rst_ni(rst_n), .rd_req_i(rd_req), .wr_req_i(wr_req),
    .rd_sel_o(got[1][0]), .rd_src_o(got[1][1]), .sense_stb_o(got[1][2]),
    .dig_en_o(got[1][3]), .wr_src_o(got[1][4]), .busy_o(got[1][5])
  );

  localparam int ON_T  [2][5] = '{'{1, 3, 22, 34, 36}, '{1, 2, 6, 11, 12}};
  localparam int OFF_T [2][5] = '{'{30, 28, 30, 60, 62}, '{5, 6, 10, 15, 18}};
  localparam int PERIOD [2]   = '{80, 22};  // LOCK_TAP+PULSE_W-1
  localparam int BUSY_LEN [2] = '{79, 21};  // LOCK_TAP+PULSE_W-2

  int    edge_n;
  int    last_l [2];
  bit    act [2];
  bit    prev_req;
  string phase = "R1 reset";
  int    checks = 0;
  int    fails = 0;
  bit    done = 1'b0;

  function automatic logic [5:0] expect_out(int d, int n);
    logic [5:0] v;
    for (int k = 0; k < 5; k++) v[k] = (n >= ON_T[d][k]) && (n < OFF_T[d][k]);
    v[5] = (n < BUSY_LEN[d]);
    return v;
  endfunction

  function automatic string sig_name(int b);
    case (b)
      0: return "rd_sel R4";
      1: return "rd_src R4";
      2: return "sense_stb R4";
      3: return "dig_en R4";
      4: return "wr_src R4";
      default: return "busy R5";
    endcase
  endfunction

  // reference launch record (R2, R6, R7, R8)
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_req <= 1'b0;
      edge_n   <= 0;
      for (int d = 0; d < 2; d++) begin
        act[d]    <= 1'b0;
        last_l[d] <= 0;
      end
    end else begin
      edge_n   <= edge_n + 1;
      prev_req <= rd_req | wr_req;
      for (int d = 0; d < 2; d++) begin
        if ((rd_req | wr_req) && !prev_req && (!act[d] || (edge_n - last_l[d] >= PERIOD[d]))) begin
          act[d]    <= 1'b1;
          last_l[d] <= edge_n;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      for (int d = 0; d < 2; d++) begin
        logic [5:0] e;
        e = act[d] ? expect_out(d, edge_n - 1 - last_l[d]) : 6'b0;
        for (int b = 0; b < 6; b++) begin
          checks++;
          if (got[d][b] !== e[b]) begin
            fails++;
            $display("FAIL [%s] dut%0d %s got %0b exp %0b at edge %0d",
                     phase, d, sig_name(b), got[d][b], e[b], edge_n);
          end
        end
        checks++;
        if (got[d][2] === 1'b1 && got[d][3] === 1'b1) begin
          fails++;
          $display("FAIL [%s] dut%0d R9 overlap got 1 exp 0", phase, d);
        end
      end
    end
  end

  task automatic step(int n);
    repeat (n) begin
      @(negedge clk);
      #1;
    end
  endtask

  initial begin
    phase = "R1 reset";
    step(4);
    rst_n = 1'b1;
    step(3);

    phase = "R2 R3 R4 R5 read";
    rd_req = 1'b1; step(1); rd_req = 1'b0;
    step(100);

    phase = "R2 R3 R4 R5 write";
    wr_req = 1'b1; step(1); wr_req = 1'b0;
    step(100);

    phase = "R6 R8 sweep";
    for (int off = 1; off <= 82; off++) begin
      rd_req = 1'b1; step(1); rd_req = 1'b0;
      step(off - 1);
      wr_req = 1'b1; step(1); wr_req = 1'b0;
      step(100);
    end

    phase = "R7 held";
    rd_req = 1'b1; step(250); rd_req = 1'b0;
    step(90);

    phase = "R8 toggle";
    for (int i = 0; i < 300; i++) begin
      rd_req = ~rd_req;
      step(1);
    end
    rd_req = 1'b0;
    step(90);

    phase = "R10 mid reset";
    wr_req = 1'b1; step(1); wr_req = 1'b0;
    step(40);
    rst_n = 1'b0; step(3); rst_n = 1'b1;
    step(100);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired got running exp finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule